// File: doc/BRIEF.md
# Timer Compare and Pin Event Unit

This unit sits beside a free-running timer counter. It watches the live count, compares it with a programmable match value and turns the resulting match events, together with the counter's overflow strobe, into a dedicated output pin and a one-cycle match interrupt pulse. The counter itself lives outside. The unit receives its present count, a strobe that marks a freshly loaded count value, and its overflow strobe.

The match value may change at any time, whether the counter runs or not. Prescaling can hold one count value for many clocks, so a match fires only once for each count value. It fires again only when the counter presents a new value or when a new match value makes the comparison true. A two-bit trigger selector picks which events drive the pin. A mode bit picks whether each event gives a one-clock high pulse or inverts the pin. While no trigger is selected, the pin rests at a programmable default level.

Top module: `tcmp_pwm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pin_o` and `match_irq_o` are 0.
- R2: A match is the condition `cmp_en_i`=1 and `cnt_i`=`match_val_i`. With `cmp_en_i`=0, no match is ever seen, whatever the count and match value.
- R3: `match_irq_o` is high for exactly the one cycle after a match is seen with `match_ie_i`=1. When `match_ie_i`=0, `match_irq_o` stays 0.
- R4: While equality holds on consecutive cycles and `cnt_adv_i`=0, only the first such cycle counts as a match. A cycle with `cnt_adv_i`=1 and equality counts as a new match.
- R5: If `match_val_i` changes to the value the count already holds, that cycle counts as a match.
- R6: The trigger selector `trig_sel_i` uses 2'b00 for none and 2'b11 for reserved, which behaves as none. In either case `pin_o` takes the value of `idle_level_i` one cycle later.
- R7: With `trig_sel_i`=2'b01, only `ovf_i` is a pin event. Matches leave the pin untouched.
- R8: With `trig_sel_i`=2'b10, a cycle with `ovf_i`=1, a match, or both is one pin event.
- R9: In pulse mode (`toggle_mode_i`=0) with a trigger selected, `pin_o` is 1 in the cycle after an event and 0 in the cycle after a cycle with no event.
- R10: In toggle mode (`toggle_mode_i`=1) with a trigger selected, `pin_o` inverts in the cycle after each event and holds otherwise. An overflow and a match in the same cycle invert it only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | W | Live counter value |
| cnt_adv_i | input | 1 | Counter presents a newly loaded value this cycle |
| ovf_i | input | 1 | Counter overflow strobe |
| match_val_i | input | W | Match value |
| cmp_en_i | input | 1 | Compare enable |
| match_ie_i | input | 1 | Match interrupt enable |
| trig_sel_i | input | 2 | Pin event selector: 00 none, 01 overflow, 10 overflow or match, 11 none |
| toggle_mode_i | input | 1 | 0 = pulse per event, 1 = invert per event |
| idle_level_i | input | 1 | Pin level while no trigger is selected |
| pin_o | output | 1 | Event output pin |
| match_irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
An overflow strobe and a fresh match can arrive in the same clock. In toggle mode this is the case that decides whether the pin inverts once or twice. The bench forces it directly: with selector 10 and toggle mode, it applies a cycle in which the count equals the match value, the advance strobe is high and the overflow strobe is high. It then expects exactly one inversion together with an interrupt pulse. The random phase produces the same coincidence repeatedly across both modes, and a reference model in the bench judges every cycle against R8 and R10.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   typedef enum logic [1:0] {
      TRIG_NONE      = 2'b00,
      TRIG_OVF       = 2'b01,
      TRIG_OVF_MATCH = 2'b10,
      TRIG_RSVD      = 2'b11
   } trig_sel_e;
endpackage

// File: rtl/tcmp_match_det.sv
module tcmp_match_det #(
   parameter int W              = 16,
   parameter bit ONCE_PER_VALUE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_i,
   input  logic         cnt_adv_i,
   input  logic [W-1:0] match_val_i,
   input  logic         cmp_en_i,
   output logic         hit_o
);
   logic eq_now;

   assign eq_now = cmp_en_i && (cnt_i == match_val_i);

   generate
      if (ONCE_PER_VALUE) begin : g_once
         // remembers that equality already held in the previous cycle
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= eq_now;
         end
         assign hit_o = eq_now && (!seen_q || cnt_adv_i);
      end else begin : g_level
         assign hit_o = eq_now;
      end
   endgenerate
endmodule

// File: rtl/tcmp_pin_drv.sv
module tcmp_pin_drv
   import tcmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf_i,
   input  logic       hit_i,
   input  logic [1:0] trig_sel_i,
   input  logic       toggle_mode_i,
   input  logic       idle_level_i,
   output logic       pin_o
);
   trig_sel_e sel;
   logic      evt;
   logic      armed;
   logic      pin_d;
   logic      pin_q;

   assign sel = trig_sel_e'(trig_sel_i);

   always_comb begin
      armed = 1'b1;
      evt   = 1'b0;
      unique case (sel)
         TRIG_OVF:       evt = ovf_i;
         TRIG_OVF_MATCH: evt = ovf_i | hit_i;
         default:        armed = 1'b0;
      endcase
   end

   always_comb begin
      if (!armed)             pin_d = idle_level_i;
      else if (toggle_mode_i) pin_d = pin_q ^ evt;
      else                    pin_d = evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end

   assign pin_o = pin_q;
endmodule

// File: rtl/tcmp_pwm.sv
module tcmp_pwm #(
   parameter int W              = 16,
   parameter bit ONCE_PER_VALUE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_i,
   input  logic         cnt_adv_i,
   input  logic         ovf_i,
   input  logic [W-1:0] match_val_i,
   input  logic         cmp_en_i,
   input  logic         match_ie_i,
   input  logic [1:0]   trig_sel_i,
   input  logic         toggle_mode_i,
   input  logic         idle_level_i,
   output logic         pin_o,
   output logic         match_irq_o
);
   localparam int CNT_MAX = W;

   generate
      if (CNT_MAX < 2 || CNT_MAX > 64) begin : g_bad_width
         $error("tcmp_pwm: W must lie in 2..64");
      end
   endgenerate

   logic hit;
   logic irq_q;

   tcmp_match_det #(
      .W              (W),
      .ONCE_PER_VALUE (ONCE_PER_VALUE)
   ) i_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_i       (cnt_i),
      .cnt_adv_i   (cnt_adv_i),
      .match_val_i (match_val_i),
      .cmp_en_i    (cmp_en_i),
      .hit_o       (hit)
   );

   tcmp_pin_drv i_pin (
      .clk           (clk),
      .rst_n         (rst_n),
      .ovf_i         (ovf_i),
      .hit_i         (hit),
      .trig_sel_i    (trig_sel_i),
      .toggle_mode_i (toggle_mode_i),
      .idle_level_i  (idle_level_i),
      .pin_o         (pin_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= hit && match_ie_i;
   end

   assign match_irq_o = irq_q;
endmodule

// File: rtl/tcmp_pwm_chk.sv
module tcmp_pwm_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] cnt_i,
   input logic         ovf_i,
   input logic [W-1:0] match_val_i,
   input logic         cmp_en_i,
   input logic         match_ie_i,
   input logic [1:0]   trig_sel_i,
   input logic         toggle_mode_i,
   input logic         idle_level_i,
   input logic         pin_o,
   input logic         match_irq_o
);
   // R3: interrupt only after an enabled compare with interrupt enable
   a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq_o |-> ($past(match_ie_i) && $past(cmp_en_i)));

   // R2: no compare, no interrupt
   a_r2_no_cmp_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en_i |=> !match_irq_o);

   // R6: default level while no trigger is selected
   a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel_i == 2'b00 || trig_sel_i == 2'b11) |=> (pin_o == $past(idle_level_i)));

   // R9: pulse mode drops the pin when no overflow on overflow-only selection
   a_r9_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel_i == 2'b01 && !toggle_mode_i && !ovf_i) |=> !pin_o);

   // R7 and R10: toggle mode holds the pin when no overflow on overflow-only selection
   a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel_i == 2'b01 && toggle_mode_i && !ovf_i) |=> $stable(pin_o));

   // R10: toggle mode inverts on an overflow
   a_r10_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel_i == 2'b01 && toggle_mode_i && ovf_i) |=> (pin_o != $past(pin_o)));

   // R8: a match with no overflow under the combined selection never leaves the pulse low
   a_r8_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel_i == 2'b10 && !toggle_mode_i && !ovf_i && cmp_en_i && match_ie_i
       && cnt_i == match_val_i) |=> (pin_o == match_irq_o));
endmodule

bind tcmp_pwm tcmp_pwm_chk #(.W(W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cnt_i         (cnt_i),
   .ovf_i         (ovf_i),
   .match_val_i   (match_val_i),
   .cmp_en_i      (cmp_en_i),
   .match_ie_i    (match_ie_i),
   .trig_sel_i    (trig_sel_i),
   .toggle_mode_i (toggle_mode_i),
   .idle_level_i  (idle_level_i),
   .pin_o         (pin_o),
   .match_irq_o   (match_irq_o)
);

// File: tb/test_tcmp_pwm.sv
module test_tcmp_pwm;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt_i = '0;
   logic         cnt_adv_i = 1'b0;
   logic         ovf_i = 1'b0;
   logic [W-1:0] match_val_i = '0;
   logic         cmp_en_i = 1'b0;
   logic         match_ie_i = 1'b0;
   logic [1:0]   trig_sel_i = 2'b00;
   logic         toggle_mode_i = 1'b0;
   logic         idle_level_i = 1'b0;
   logic         pin_o;
   logic         match_irq_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // reference state
   logic seen_m = 1'b0;
   logic pin_m  = 1'b0;
   logic irq_m  = 1'b0;

   always #5 clk = ~clk;

   tcmp_pwm #(.W(W)) i_tcmp_pwm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_i         (cnt_i),
      .cnt_adv_i     (cnt_adv_i),
      .ovf_i         (ovf_i),
      .match_val_i   (match_val_i),
      .cmp_en_i      (cmp_en_i),
      .match_ie_i    (match_ie_i),
      .trig_sel_i    (trig_sel_i),
      .toggle_mode_i (toggle_mode_i),
      .idle_level_i  (idle_level_i),
      .pin_o         (pin_o),
      .match_irq_o   (match_irq_o)
   );

   function automatic logic f_hit(logic en, logic [W-1:0] c, logic [W-1:0] m,
                                  logic adv, logic seen);
      return en && (c == m) && (!seen || adv);
   endfunction

   function automatic logic f_pin(logic [1:0] sel, logic tgl, logic idle,
                                  logic ovf, logic hit, logic cur);
      logic evt;
      if (sel == 2'b00 || sel == 2'b11) return idle;
      evt = (sel == 2'b01) ? ovf : (ovf | hit);
      return tgl ? (cur ^ evt) : evt;
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // advance one clock with the present inputs and compare both outputs
   task automatic step(input string req);
      logic hit;
      hit    = f_hit(cmp_en_i, cnt_i, match_val_i, cnt_adv_i, seen_m);
      irq_m  = hit && match_ie_i;
      pin_m  = f_pin(trig_sel_i, toggle_mode_i, idle_level_i, ovf_i, hit, pin_m);
      seen_m = cmp_en_i && (cnt_i == match_val_i);
      @(posedge clk);
      #2;
      cycles++;
      check(req, pin_o, pin_m, "pin_o");
      check(req, match_irq_o, irq_m, "match_irq_o");
   endtask

   task automatic set_in(input logic [W-1:0] c, input logic adv, input logic ov,
                         input logic [W-1:0] m);
      cnt_i = c; cnt_adv_i = adv; ovf_i = ov; match_val_i = m;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic p0;
      void'($urandom(32'd2024));
      // R1: reset state
      #23;
      check("R1", pin_o, 1'b0, "pin_o in reset");
      check("R1", match_irq_o, 1'b0, "irq in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step("R1");

      // R2: equality without compare enable
      cmp_en_i = 1'b0; match_ie_i = 1'b1; trig_sel_i = 2'b10;
      set_in(8'd5, 1'b1, 1'b0, 8'd5);
      step("R2");
      // R2, R3, R9: enable compare, equality present -> irq and pulse
      cmp_en_i = 1'b1;
      step("R3");
      check("R9", pin_o, 1'b1, "pulse after match");
      // R4: held equality, no advance -> nothing
      cnt_adv_i = 1'b0;
      step("R4");
      check("R4", match_irq_o, 1'b0, "no repeat match");
      step("R4");
      // R4: advance to same value re-arms
      cnt_adv_i = 1'b1;
      step("R4");
      check("R4", match_irq_o, 1'b1, "rearm on advance");
      // R5: match value written equal to live count
      set_in(8'd9, 1'b0, 1'b0, 8'd3);
      step("R5");
      match_val_i = 8'd9;
      step("R5");
      check("R5", match_irq_o, 1'b1, "match on value write");
      // R3: interrupt disabled
      match_ie_i = 1'b0;
      set_in(8'd4, 1'b1, 1'b0, 8'd4);
      step("R3");
      check("R3", match_irq_o, 1'b0, "irq masked");
      match_ie_i = 1'b1;
      // R6: none and reserved follow the default level
      trig_sel_i = 2'b00; idle_level_i = 1'b1;
      step("R6");
      check("R6", pin_o, 1'b1, "idle high");
      trig_sel_i = 2'b11; idle_level_i = 1'b0;
      step("R6");
      check("R6", pin_o, 1'b0, "reserved idle low");
      // R7: overflow only ignores match (toggle mode)
      trig_sel_i = 2'b01; toggle_mode_i = 1'b1;
      set_in(8'd7, 1'b1, 1'b0, 8'd7);
      step("R7");
      check("R7", pin_o, 1'b0, "match ignored");
      // R10: overflow and match same cycle invert once
      trig_sel_i = 2'b10;
      set_in(8'd6, 1'b1, 1'b1, 8'd6);
      p0 = pin_o;
      step("R10");
      check("R10", pin_o, ~p0, "single inversion");
      check("R10", match_irq_o, 1'b1, "irq with overflow");
      // R8: overflow alone under combined selection
      set_in(8'd1, 1'b1, 1'b1, 8'd6);
      p0 = pin_o;
      step("R8");
      check("R8", pin_o, ~p0, "overflow inverts");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 15) == 0) begin
            trig_sel_i    = 2'($urandom_range(0, 3));
            toggle_mode_i = 1'($urandom_range(0, 1));
            idle_level_i  = 1'($urandom_range(0, 1));
            cmp_en_i      = ($urandom_range(0, 4) != 0);
            match_ie_i    = ($urandom_range(0, 3) != 0);
         end
         cnt_adv_i = 1'($urandom_range(0, 1));
         if (cnt_adv_i) cnt_i = 8'($urandom_range(0, 5));
         if ($urandom_range(0, 9) == 0) match_val_i = 8'($urandom_range(0, 5));
         ovf_i = ($urandom_range(0, 5) == 0);
         step("R8 R9 R10 R4");
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule